// File: doc/BRIEF.md
# Daisy-Chain Addressed Serial Slave

This block is a serial slave for mode 0 that sits in a cascade of identical devices. All devices share one serial clock and one active-low select line. Each device passes its serial output to the serial input of the next device, and the first device receives the master's output line. Because every device sees all of the traffic, each packet carries the address of the device it is meant for.

While select is low, the block shifts every incoming bit into a shift register one packet long. It sends the bit that falls out of that register on to its own serial output, so the stream reaches the next device 16 serial clock cycles later. When select goes high, the block looks at the 16 bits it holds. The top 4 bits are the address and the low 12 bits are the data. If the address equals the block's strapped address and the frame held a whole, non-zero number of packets, the block loads the data into its output register and pulses an update strobe.

The block runs on a system clock. The serial clock, data and select inputs pass through two-flop synchronizers, and the serial clock edges are detected from the synchronized copy. The serial clock must therefore stay well below the system clock rate.

Top module: `spi_chain_node`

## Requirements
- R1: After reset, `sdo` is 0, `reg_q` is 0 and `upd_stb` is 0.
- R2: Mode 0 timing applies: `sdi` is sampled on each rising `sck` edge while `sel_n` is low, and `sdo` changes only after a falling `sck` edge. The value on `sdo` before rising edge n equals the bit sampled at rising edge n-16. This counts across frames, and the shift register starts at zero after reset.
- R3: When `sel_n` rises after a non-zero multiple of 16 rising edges, and bits [15:12] of the held packet equal `NODE_ADDR`, then `reg_q` takes bits [11:0] and `upd_stb` pulses. Bits are sent MSB first, so the first bit of the packet becomes bit 15.
- R4: A packet whose address field differs from `NODE_ADDR` leaves `reg_q` unchanged and causes no strobe.
- R5: A frame whose rising-edge count is zero or is not a multiple of 16 is malformed. It leaves `reg_q` unchanged and causes no strobe.
- R6: In a frame of 32 or more bits, only the last 16 bits are decoded. Earlier packets are only passed on.
- R7: `upd_stb` is high for exactly one system clock per accepted packet, and `reg_q` changes only in the cycle in which `upd_stb` is high.
- R8: The bit count restarts each time `sel_n` falls, so a truncated frame does not shift the packet alignment of the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the master, idle low |
| sdi | input | 1 | Serial data in, from the master or the previous device |
| sel_n | input | 1 | Shared active-low select |
| sdo | output | 1 | Serial data out, to the next device |
| reg_q | output | 12 | Data register, loaded by accepted packets |
| upd_stb | output | 1 | One-cycle pulse when `reg_q` is loaded |

## Verification
The bench builds the block with `NODE_ADDR` set to 4'hA and the default 4-bit address and 12-bit data fields. With a 16-bit register and an address the test chooses, it can send matching and non-matching packets, frames of 12 and 17 bits, an empty frame, and a 32-bit frame in which the packet for this device is the second one. With a serial half period of 8 system clocks, the bench can compare `sdo` with a 16-bit delayed model on every bit, across frame boundaries.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 12;
    localparam int PKT_W  = ADDR_W + DATA_W;
    localparam int CNT_W  = $clog2(PKT_W);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } pkt_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edges_t;

    function automatic pkt_t to_pkt(input logic [PKT_W-1:0] raw);
        return pkt_t'(raw);
    endfunction

    // a frame is whole when at least one bit arrived and the count wrapped to zero
    function automatic logic frame_whole(input logic [CNT_W-1:0] cnt, input logic any);
        return any && (cnt == '0);
    endfunction

endpackage

// File: rtl/spi_chain_sync.sv
module spi_chain_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= INIT;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= INIT;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_chain_edge.sv
module spi_chain_edge
    import spi_chain_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sck_s,
    input  logic   sel_n_s,
    output edges_t sck_ev,
    output edges_t sel_ev
);

    logic sck_d;
    logic sel_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            sel_d <= 1'b1;
        end else begin
            sck_d <= sck_s;
            sel_d <= sel_n_s;
        end
    end

    always_comb begin
        sck_ev.rise = sck_s & ~sck_d;
        sck_ev.fall = ~sck_s & sck_d;
        sel_ev.rise = sel_n_s & ~sel_d;
        sel_ev.fall = ~sel_n_s & sel_d;
    end

endmodule

// File: rtl/spi_chain_shift.sv
module spi_chain_shift
    import spi_chain_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic shift_en,
    input  logic out_en,
    input  logic sdi_s,
    output logic sdo,
    output pkt_t pkt,
    output logic whole
);

    logic [PKT_W-1:0] sreg;
    logic [CNT_W-1:0] bit_cnt;
    logic             any_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg    <= '0;
            bit_cnt <= '0;
            any_bit <= 1'b0;
            sdo     <= 1'b0;
        end else begin
            if (frame_start) begin
                bit_cnt <= '0;
                any_bit <= 1'b0;
            end else if (shift_en) begin
                sreg    <= {sreg[PKT_W-2:0], sdi_s};
                any_bit <= 1'b1;
                bit_cnt <= (bit_cnt == CNT_W'(PKT_W-1)) ? '0 : bit_cnt + 1'b1;
            end
            if (out_en) sdo <= sreg[PKT_W-1];
        end
    end

    assign pkt   = to_pkt(sreg);
    assign whole = frame_whole(bit_cnt, any_bit);

    // R2
    sdo_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> $past(out_en));

    // R8
    cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (bit_cnt == '0 && !any_bit));

endmodule

// File: rtl/spi_chain_node.sv
module spi_chain_node
    import spi_chain_pkg::*;
#(
    parameter logic [ADDR_W-1:0] NODE_ADDR   = 4'h5,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              sdi,
    input  logic              sel_n,
    output logic              sdo,
    output logic [DATA_W-1:0] reg_q,
    output logic              upd_stb
);

    logic   sck_s, sdi_s, sel_n_s;
    edges_t sck_ev, sel_ev;
    pkt_t   held;
    logic   whole;
    logic   hit;

    spi_chain_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b001)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck, sdi, sel_n}),
        .q   ({sck_s, sdi_s, sel_n_s})
    );

    spi_chain_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .sck_s   (sck_s),
        .sel_n_s (sel_n_s),
        .sck_ev  (sck_ev),
        .sel_ev  (sel_ev)
    );

    spi_chain_shift u_shift (
        .clk         (clk),
        .rst         (rst),
        .frame_start (sel_ev.fall),
        .shift_en    (sck_ev.rise & ~sel_n_s),
        .out_en      (sck_ev.fall & ~sel_n_s),
        .sdi_s       (sdi_s),
        .sdo         (sdo),
        .pkt         (held),
        .whole       (whole)
    );

    assign hit = sel_ev.rise && whole && (held.addr == NODE_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q   <= '0;
            upd_stb <= 1'b0;
        end else begin
            upd_stb <= hit;
            if (hit) reg_q <= held.data;
        end
    end

    // R7
    stb_width_chk: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> !upd_stb);

    // R7
    reg_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_q) |-> upd_stb);

    // R3
    stb_after_sel_chk: assert property (@(posedge clk) disable iff (rst)
        upd_stb |-> $past(sel_ev.rise));

endmodule

// File: tb/spi_chain_node_bench.sv
module spi_chain_node_bench;

    localparam int          HALF   = 8;
    localparam logic [3:0]  MYADDR = 4'hA;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        sel_n = 1'b1;
    logic        sdo;
    logic [11:0] reg_q;
    logic        upd_stb;

    int          n_chk = 0;
    int          n_bad = 0;
    logic        done = 1'b0;
    logic [15:0] model = '0;
    logic [11:0] exp_reg = '0;
    logic [11:0] upd_q[$];
    logic        stb_prev = 1'b0;

    always #2 clk = ~clk;

    spi_chain_node #(.NODE_ADDR(MYADDR)) u_spi_chain_node (
        .clk     (clk),
        .rst     (rst),
        .sck     (sck),
        .sdi     (sdi),
        .sel_n   (sel_n),
        .sdo     (sdo),
        .reg_q   (reg_q),
        .upd_stb (upd_stb)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected updates when the strobe appears
    always @(negedge clk) begin
        if (!rst) begin
            if (upd_stb) begin
                n_chk++;
                if (upd_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R4/R5: actual unexpected strobe reg_q=%h expected none", reg_q);
                end else begin
                    logic [11:0] e;
                    e = upd_q.pop_front();
                    if (reg_q !== e) begin
                        n_bad++;
                        $display("FAIL R3: actual %h expected %h", reg_q, e);
                    end
                end
                // R7 one-cycle pulse
                n_chk++;
                if (stb_prev) begin
                    n_bad++;
                    $display("FAIL R7: actual strobe 2 cycles expected 1");
                end
            end
            stb_prev = upd_stb;
        end
    end

    // driver: sends n bits MSB first, checks sdo every bit, queues the expected update
    task automatic send_frame(input logic [63:0] bits, input int n,
                              input logic accept, input logic [11:0] data, input string tag);
        sel_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = bits[n-1-i];
            sdi = b;
            wait_clk(HALF);
            check("R2 sdo", {15'd0, sdo}, {15'd0, model[15]});
            sck = 1'b1;
            model = {model[14:0], b};
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        if (accept) begin
            upd_q.push_back(data);
            exp_reg = data;
        end
        sel_n = 1'b1;
        wait_clk(12);
        check(tag, {4'd0, reg_q}, {4'd0, exp_reg});
        check("R7 pending", 16'(upd_q.size()), 16'd0);
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(1);
        check("R1 sdo", {15'd0, sdo}, 16'd0);
        check("R1 reg_q", {4'd0, reg_q}, 16'd0);
        check("R1 upd_stb", {15'd0, upd_stb}, 16'd0);

        // R3 matching address
        send_frame({48'd0, MYADDR, 12'h123}, 16, 1'b1, 12'h123, "R3 match");
        // R4 other address
        send_frame({48'd0, 4'h3, 12'hFED}, 16, 1'b0, 12'h0, "R4 mismatch");
        // R5 short frame carrying a matching address
        send_frame({52'd0, MYADDR, 8'h77}, 12, 1'b0, 12'h0, "R5 short");
        // R8 next whole frame is still aligned
        send_frame({48'd0, MYADDR, 12'h456}, 16, 1'b1, 12'h456, "R8 realign");
        // R5 empty frame
        send_frame(64'd0, 0, 1'b0, 12'h0, "R5 empty");
        // R5 17-bit frame
        send_frame({47'd0, 1'b1, MYADDR, 12'h999}, 17, 1'b0, 12'h0, "R5 seventeen");
        // R6 two packets, only the last is decoded
        send_frame({32'd0, MYADDR, 12'h111, MYADDR, 12'h5A5}, 32, 1'b1, 12'h5A5, "R6 last");
        // R6 last packet foreign, first matches
        send_frame({32'd0, MYADDR, 12'hBBB, 4'h1, 12'h222}, 32, 1'b0, 12'h0, "R6 foreign");
        // R3 all-ones data
        send_frame({48'd0, MYADDR, 12'hFFF}, 16, 1'b1, 12'hFFF, "R3 ones");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule